// File: doc/BRIEF.md
# H-Bridge Gate Command and Fault Manager

This block sits between a motor-control processor and the gate drivers of a full bridge. It turns two direction inputs into on/off commands for the four switches: a high and a low switch on each of two output legs. Two disable inputs force both legs to high impedance, one active high and one active low. A sleep input parks the bridge, and after sleep a wake-up delay passes before the bridge may drive again. An active-low fault flag summarises the protection state.

Undervoltage blanks the bridge only while it is present. A short-circuit or over-temperature request latches the bridge off until software gives a release edge on one of the disable inputs. An over-temperature latch also needs a cooled-down indication at that edge. Each leg runs its own break-before-make timer, so the two switches of a leg never conduct together, and a leg that has just turned off stays off for a programmable number of cycles.

Top module: `hbridge_ctl`

## Requirements
- R1: With the bridge awake and no disable or fault, `dir_a_i`=1, `dir_b_i`=0 gives leg A high-side on and leg B low-side on. The mirrored inputs give the mirrored result. Bit 0 of each output vector is leg A and bit 1 is leg B.
- R2: Both direction inputs low turn on both low-side switches. Both high turn on both high-side switches.
- R3: `dis_hi_i`=1 or `dis_lo_n_i`=0 switches both legs off (`hiz_o`=2'b11) and drives `fault_n_o` low.
- R4: With `en_i` low the bridge is off and `fault_n_o` is high, even while a protection latch is held.
- R5: After the synchronised enable rises, all switches stay off until WAKE_CYC cycles of enable have passed.
- R6: `uv_i` high switches both legs off and drives `fault_n_o` low. When it drops, the bridge follows the direction inputs again and the flag returns high without any other action.
- R7: A one-cycle `short_req_i` pulse turns both legs off from the next clock edge. They stay off with `fault_n_o` low regardless of the direction inputs.
- R8: A latch is released by a falling edge of `dis_hi_i` or a rising edge of `dis_lo_n_i`, each seen after synchronisation. Changes on the direction or undervoltage inputs do not release it.
- R9: A latch set by `ot_req_i` is released only if `ot_cool_i` is high when the release edge arrives.
- R10: The high and low switch of one leg are never on in the same cycle.
- R11: Once a leg's switch turns off, neither switch of that leg turns on for the next DEAD_CYC+1 cycles.
- R12: Under reset all switches are off, `hiz_o`=2'b11 and `fault_n_o`=1.
- R13: `en_i`, `dis_hi_i` and `dis_lo_n_i` pass through two flops. A disable raised before clock edge 1 still leaves the outputs unchanged after edge 2 and takes them to high impedance after edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Bridge enable; low is sleep |
| dir_a_i | input | 1 | Requested level of leg A |
| dir_b_i | input | 1 | Requested level of leg B |
| dis_hi_i | input | 1 | Disable, active high |
| dis_lo_n_i | input | 1 | Disable, active low |
| uv_i | input | 1 | Supply undervoltage present |
| short_req_i | input | 1 | Short-circuit latch request |
| ot_req_i | input | 1 | Over-temperature latch request |
| ot_cool_i | input | 1 | Die has cooled below trip minus hysteresis |
| hs_on_o | output | 2 | High-side switch on, per leg |
| ls_on_o | output | 2 | Low-side switch on, per leg |
| hiz_o | output | 2 | Leg high impedance, per leg |
| fault_n_o | output | 1 | Fault flag, active low |

## Verification
The assertions assume that the direction, undervoltage and protection inputs are synchronous to `clk`, because they feed the next-state logic directly. They also assume that the three slow inputs hold their inactive levels while reset is asserted. The bench changes every input only on the falling clock edge. It starts each run with enable low, both disables inactive and all requests clear, and it samples only after the latency of the synchronisers, the fault latch and the leg registers has passed.

// File: rtl/hb_pkg.sv
package hb_pkg;
    // command held by one bridge leg
    typedef enum logic [1:0] {
        LEG_OFF = 2'b00,
        LEG_HI  = 2'b01,
        LEG_LO  = 2'b10
    } leg_cmd_e;

    localparam int unsigned N_LEGS = 2;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int unsigned W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] st1;
        logic [W-1:0] st2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.st1 = async_i;
        s_d.st2 = s_q.st1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st1: RST_VAL, st2: RST_VAL};
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.st2;
endmodule

// File: rtl/hb_fault.sv
module hb_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic en_s_i,
    input  logic dis_hi_s_i,
    input  logic dis_lo_s_i,
    input  logic short_req_i,
    input  logic ot_req_i,
    input  logic ot_cool_i,
    output logic sc_lat_o,
    output logic ot_lat_o
);
    typedef struct packed {
        logic hi_prev;
        logic lo_prev;
        logic sc;
        logic ot;
    } flt_t;

    flt_t f_d, f_q;
    logic release_edge;

    always_comb begin
        f_d = f_q;
        // release happens when a disable is withdrawn
        release_edge = (f_q.hi_prev & ~dis_hi_s_i) | (~f_q.lo_prev & dis_lo_s_i);
        f_d.hi_prev  = dis_hi_s_i;
        f_d.lo_prev  = dis_lo_s_i;

        if (en_s_i && short_req_i) begin
            f_d.sc = 1'b1;
        end else if (release_edge) begin
            f_d.sc = 1'b0;
        end

        if (en_s_i && ot_req_i) begin
            f_d.ot = 1'b1;
        end else if (release_edge && ot_cool_i) begin
            f_d.ot = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{hi_prev: 1'b0, lo_prev: 1'b1, sc: 1'b0, ot: 1'b0};
        end else begin
            f_q <= f_d;
        end
    end

    assign sc_lat_o = f_q.sc;
    assign ot_lat_o = f_q.ot;
endmodule

// File: rtl/hb_leg.sv
module hb_leg
    import hb_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_cmd_e want_i,
    output logic     hs_on_o,
    output logic     ls_on_o
);
    localparam int unsigned CW = $clog2(DEAD_CYC + 1);

    typedef struct packed {
        leg_cmd_e      cmd;
        logic [CW-1:0] cnt;
    } leg_t;

    leg_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (l_q.cmd != LEG_OFF) begin
            // any change leaves through the off state with a fresh gap
            if (want_i != l_q.cmd) begin
                l_d.cmd = LEG_OFF;
                l_d.cnt = CW'(DEAD_CYC);
            end
        end else if (l_q.cnt != '0) begin
            l_d.cnt = l_q.cnt - 1'b1;
        end else begin
            l_d.cmd = want_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '{cmd: LEG_OFF, cnt: '0};
        end else begin
            l_q <= l_d;
        end
    end

    assign hs_on_o = (l_q.cmd == LEG_HI);
    assign ls_on_o = (l_q.cmd == LEG_LO);
endmodule

// File: rtl/hbridge_ctl.sv
module hbridge_ctl
    import hb_pkg::*;
#(
    parameter int unsigned WAKE_CYC = 100000,
    parameter int unsigned DEAD_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       dir_a_i,
    input  logic       dir_b_i,
    input  logic       dis_hi_i,
    input  logic       dis_lo_n_i,
    input  logic       uv_i,
    input  logic       short_req_i,
    input  logic       ot_req_i,
    input  logic       ot_cool_i,
    output logic [1:0] hs_on_o,
    output logic [1:0] ls_on_o,
    output logic [1:0] hiz_o,
    output logic       fault_n_o
);
    localparam int unsigned WAKE_W = $clog2(WAKE_CYC + 1);

    typedef struct packed {
        logic [WAKE_W-1:0] wake;
        logic              fault_n;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [2:0]        slow_s;
    logic              en_s, dis_lo_s, dis_hi_s;
    logic              sc_lat, ot_lat;
    logic              awake, dis_act, lat_any, block;
    logic [N_LEGS-1:0] dir;
    leg_cmd_e          want [N_LEGS];

    // bit 2 enable, bit 1 active-low disable, bit 0 active-high disable
    hb_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({en_i, dis_lo_n_i, dis_hi_i}),
        .sync_o  (slow_s)
    );
    assign en_s     = slow_s[2];
    assign dis_lo_s = slow_s[1];
    assign dis_hi_s = slow_s[0];

    hb_fault u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_s_i      (en_s),
        .dis_hi_s_i  (dis_hi_s),
        .dis_lo_s_i  (dis_lo_s),
        .short_req_i (short_req_i),
        .ot_req_i    (ot_req_i),
        .ot_cool_i   (ot_cool_i),
        .sc_lat_o    (sc_lat),
        .ot_lat_o    (ot_lat)
    );

    assign dir = {dir_b_i, dir_a_i};

    always_comb begin
        c_d     = c_q;
        awake   = en_s && (c_q.wake == WAKE_W'(WAKE_CYC));
        dis_act = dis_hi_s | ~dis_lo_s;
        lat_any = sc_lat | ot_lat;
        // a fresh protection request blanks the bridge before it latches
        block   = ~awake | dis_act | uv_i | lat_any | short_req_i | ot_req_i;

        if (!en_s) begin
            c_d.wake = '0;
        end else if (!awake) begin
            c_d.wake = c_q.wake + 1'b1;
        end

        c_d.fault_n = en_s ? ~(dis_act | uv_i | lat_any) : 1'b1;

        for (int k = 0; k < N_LEGS; k++) begin
            if (block) begin
                want[k] = LEG_OFF;
            end else begin
                want[k] = dir[k] ? LEG_HI : LEG_LO;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{wake: '0, fault_n: 1'b1};
        end else begin
            c_q <= c_d;
        end
    end

    for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
        hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .want_i  (want[g]),
            .hs_on_o (hs_on_o[g]),
            .ls_on_o (ls_on_o[g])
        );
        assign hiz_o[g] = ~(hs_on_o[g] | ls_on_o[g]);
    end

    assign fault_n_o = c_q.fault_n;
endmodule

// File: rtl/hb_ctl_chk.sv
module hb_ctl_chk #(
    parameter int unsigned WAKE_CYC = 100000,
    parameter int unsigned DEAD_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       dir_a_i,
    input logic       dir_b_i,
    input logic       dis_hi_i,
    input logic       dis_lo_n_i,
    input logic       uv_i,
    input logic       short_req_i,
    input logic [1:0] hs_on_o,
    input logic [1:0] ls_on_o,
    input logic [1:0] hiz_o,
    input logic       fault_n_o
);
    localparam int unsigned RW = $clog2(WAKE_CYC + 2);
    localparam int unsigned DW = $clog2(DEAD_CYC + 2);

    logic [1:0]    dir;
    logic [2:0]    en_dl;
    logic [RW-1:0] en_run;
    logic [1:0]    age;
    logic [DW-1:0] off_run [2];

    assign dir = {dir_b_i, dir_a_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_dl  <= '0;
            en_run <= '0;
            age    <= '0;
        end else begin
            en_dl <= {en_dl[1:0], en_i};
            if (!en_dl[2]) begin
                en_run <= '0;
            end else if (en_run < RW'(WAKE_CYC)) begin
                en_run <= en_run + 1'b1;
            end
            if (age != 2'd3) begin
                age <= age + 1'b1;
            end
        end
    end

    for (genvar k = 0; k < 2; k++) begin : g_leg_chk
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                off_run[k] <= DW'(DEAD_CYC);
            end else if (hs_on_o[k] | ls_on_o[k]) begin
                off_run[k] <= '0;
            end else if (off_run[k] < DW'(DEAD_CYC)) begin
                off_run[k] <= off_run[k] + 1'b1;
            end
        end

        // R1: a driven switch matches the direction input of the previous cycle
        a_r1_hs_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
            hs_on_o[k] |-> $past(dir[k]));
        a_r1_ls_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
            ls_on_o[k] |-> !$past(dir[k]));
        // R10
        a_r10_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
            !(hs_on_o[k] && ls_on_o[k]));
        // R11
        a_r11_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
            ((hs_on_o[k] | ls_on_o[k]) && !$past(hs_on_o[k] | ls_on_o[k]))
            |-> (off_run[k] >= DW'(DEAD_CYC)));
    end

    // R3
    a_r3_dis_hi_off: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(dis_hi_i, 3)) |-> (hiz_o == 2'b11));
    a_r3_dis_lo_off: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && !$past(dis_lo_n_i, 3)) |-> (hiz_o == 2'b11));
    a_r3_dis_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(en_i, 3) && $past(dis_hi_i, 3)) |-> !fault_n_o);
    // R4
    a_r4_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && !$past(en_i, 3)) |-> (hiz_o == 2'b11 && fault_n_o));
    // R5
    a_r5_wake_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ((|hs_on_o) || (|ls_on_o)) |-> (en_run >= RW'(WAKE_CYC)));
    // R6
    a_r6_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(uv_i) |-> (hiz_o == 2'b11));
    // R7
    a_r7_short_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(short_req_i) |-> (hiz_o == 2'b11));
endmodule

bind hbridge_ctl hb_ctl_chk #(.WAKE_CYC(WAKE_CYC), .DEAD_CYC(DEAD_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .dir_a_i     (dir_a_i),
    .dir_b_i     (dir_b_i),
    .dis_hi_i    (dis_hi_i),
    .dis_lo_n_i  (dis_lo_n_i),
    .uv_i        (uv_i),
    .short_req_i (short_req_i),
    .hs_on_o     (hs_on_o),
    .ls_on_o     (ls_on_o),
    .hiz_o       (hiz_o),
    .fault_n_o   (fault_n_o)
);

// File: tb/hbridge_ctl_tb.sv
module hbridge_ctl_tb;
    localparam int unsigned WAKE = 20;
    localparam int unsigned DEAD = 3;
    localparam int unsigned NV   = 10;

    // fields: a b dh dln uv | hs[1:0] ls[1:0] hiz[1:0] fault_n
    localparam logic [11:0] VEC [NV] = '{
        12'b1_0_0_1_0_01_10_00_1,
        12'b0_1_0_1_0_10_01_00_1,
        12'b0_0_0_1_0_00_11_00_1,
        12'b1_1_0_1_0_11_00_00_1,
        12'b1_0_1_1_0_00_00_11_0,
        12'b1_0_0_1_0_01_10_00_1,
        12'b1_0_0_0_0_00_00_11_0,
        12'b1_0_0_1_0_01_10_00_1,
        12'b0_1_0_1_1_00_00_11_0,
        12'b0_1_0_1_0_10_01_00_1
    };
    localparam string TAGS [NV] = '{"R1", "R1", "R2", "R2", "R3",
                                    "R3", "R3", "R3", "R6", "R6"};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, a = 1'b0, b = 1'b0, dh = 1'b0, dln = 1'b1;
    logic       uv = 1'b0, sc = 1'b0, ot = 1'b0, cool = 1'b1;
    logic [1:0] hs, ls, hiz;
    logic       fn;
    int         n_chk = 0;
    int         n_err = 0;

    always #5 clk = ~clk;

    hbridge_ctl #(.WAKE_CYC(WAKE), .DEAD_CYC(DEAD)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .dir_a_i     (a),
        .dir_b_i     (b),
        .dis_hi_i    (dh),
        .dis_lo_n_i  (dln),
        .uv_i        (uv),
        .short_req_i (sc),
        .ot_req_i    (ot),
        .ot_cool_i   (cool),
        .hs_on_o     (hs),
        .ls_on_o     (ls),
        .hiz_o       (hiz),
        .fault_n_o   (fn)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_state(input string tag, input logic [6:0] exp);
        logic [6:0] act;
        act = {hs, ls, hiz, fn};
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: {hs,ls,hiz,fault_n} got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic pulse_dh();
        dh = 1'b1;
        step(6);
        dh = 1'b0;
        step(12);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete, got timeout expected end");
        finish_run();
    end

    initial begin
        step(3);
        expect_state("R12", 7'b00_00_11_1);
        rst_n = 1'b1;

        en = 1'b1; a = 1'b1; b = 1'b0;
        step(5);
        expect_state("R5", 7'b00_00_11_1);
        step(WAKE + 10);
        expect_state("R1", 7'b01_10_00_1);

        for (int i = 0; i < int'(NV); i++) begin
            {a, b, dh, dln, uv} = VEC[i][11:7];
            step(12);
            expect_state(TAGS[i], VEC[i][6:0]);
        end

        // R13: disable latency through the synchroniser
        a = 1'b1; b = 1'b0;
        step(12);
        dh = 1'b1;
        step(2);
        expect_state("R13", 7'b01_10_00_1);
        step(1);
        expect_state("R13", 7'b00_00_11_0);
        dh = 1'b0;
        step(12);

        // R11 and R10: leg A goes from high to low through a gap
        a = 1'b0;
        step(1);
        expect_state("R11", 7'b00_10_01_1);
        for (int i = 0; i < int'(DEAD); i++) begin
            step(1);
            expect_state("R11", 7'b00_10_01_1);
        end
        step(1);
        expect_state("R10", 7'b00_11_00_1);

        // R7: short latch ignores the direction inputs
        a = 1'b1;
        step(12);
        sc = 1'b1;
        step(1);
        sc = 1'b0;
        step(5);
        expect_state("R7", 7'b00_00_11_0);
        a = 1'b0; b = 1'b1;
        step(12);
        expect_state("R7", 7'b00_00_11_0);

        // R8: rising edge of the active-low disable releases
        dln = 1'b0;
        step(6);
        dln = 1'b1;
        step(12);
        expect_state("R8", 7'b10_01_00_1);

        // R8: other inputs do not release, falling active-high disable does
        sc = 1'b1;
        step(1);
        sc = 1'b0;
        uv = 1'b1;
        step(3);
        uv = 1'b0; a = 1'b1;
        step(4);
        a = 1'b0;
        step(12);
        expect_state("R8", 7'b00_00_11_0);
        pulse_dh();
        expect_state("R8", 7'b10_01_00_1);

        // R9: over-temperature needs the cool indication
        ot = 1'b1;
        step(1);
        ot = 1'b0; cool = 1'b0;
        step(5);
        expect_state("R9", 7'b00_00_11_0);
        pulse_dh();
        expect_state("R9", 7'b00_00_11_0);
        cool = 1'b1;
        pulse_dh();
        expect_state("R9", 7'b10_01_00_1);

        // R4: sleep raises the flag over a held latch; R5 wake again
        sc = 1'b1;
        step(1);
        sc = 1'b0;
        en = 1'b0;
        step(6);
        expect_state("R4", 7'b00_00_11_1);
        en = 1'b1;
        step(5);
        expect_state("R5", 7'b00_00_11_0);
        pulse_dh();
        step(WAKE);
        expect_state("R5", 7'b10_01_00_1);

        // R12: reset in mid-run
        rst_n = 1'b0;
        step(1);
        expect_state("R12", 7'b00_00_11_1);
        rst_n = 1'b1;
        step(2);

        finish_run();
    end
endmodule